// File: doc/BRIEF.md
# Dual-mode serial port arbiter

This block decides which of two engines owns a shared serial data line. One engine is a transmit-only streamer clocked by a dedicated stream clock. The other is a bidirectional slave front end clocked by a separate bus clock. After reset the streamer owns the line. A clean falling edge on the bus clock hands the line to the slave. The slave then reports whether the master addressed it with its control byte.

While the slave owns the line, the arbiter counts rising edges of the stream clock. Every matched control byte restarts that count. If 128 stream-clock edges arrive with no match in between, the arbiter hands the line back to the streamer. At the same moment it sends the streamer a one-cycle reset, so the streamer runs its start-up sequence again.

Both clock lines are asynchronous to the system clock, so each passes through a synchronizer. The data-line enable and value that leave the block always come from the engine of the current mode only.

Top module: `serial_mode_arbiter`

## Requirements
- R1: After reset the block is in transmit-only mode: stream_en_o=1, slave_en_o=0 and stream_rst_o=0.
- R2: A falling edge of bclk_i that follows at least MIN_HIGH (default 2) consecutive synchronized high samples switches the block to bidirectional mode (stream_en_o=0, slave_en_o=1) within 5 system clocks.
- R3: A falling edge of bclk_i after fewer than MIN_HIGH high samples is ignored, and the mode stays transmit-only.
- R4: In bidirectional mode without a match, the block returns to transmit-only mode on the 128th (TIMEOUT) rising edge of tclk_i counted from entry. After 127 edges it is still bidirectional.
- R5: A match (ctl_valid_i=1 together with ctl_hit_i=1) in bidirectional mode restarts the window. The block then reverts on the 128th tclk_i rising edge after the match, not before.
- R6: A no-match report (ctl_valid_i=1 with ctl_hit_i=0) has no effect: it neither restarts the window nor changes the mode.
- R7: A match report while in transmit-only mode is ignored: the mode stays transmit-only.
- R8: Further valid bclk_i falling edges while in bidirectional mode are ignored and do not restart the window.
- R9: Each return to transmit-only mode raises stream_rst_o for exactly one system clock.
- R10: In transmit-only mode, sda_oe_o and sda_o equal stream_oe_i and stream_sda_i. In bidirectional mode they equal slave_oe_i and slave_sda_i. The other engine's inputs have no effect, and exactly one of stream_en_o and slave_en_o is high at any time.
- R11: tclk_i edges seen in transmit-only mode are not counted, so they do not shorten the next bidirectional window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bidirectional bus clock line, asynchronous |
| tclk_i | input | 1 | Transmit-only stream clock, asynchronous |
| ctl_valid_i | input | 1 | Slave front end reports a control-byte decode result |
| ctl_hit_i | input | 1 | Decode result: 1 = match, 0 = no match |
| stream_oe_i | input | 1 | Streamer data-line drive enable |
| stream_sda_i | input | 1 | Streamer data-line value |
| slave_oe_i | input | 1 | Slave data-line drive enable |
| slave_sda_i | input | 1 | Slave data-line value |
| stream_en_o | output | 1 | Streamer enabled (transmit-only mode) |
| slave_en_o | output | 1 | Slave enabled (bidirectional mode) |
| stream_rst_o | output | 1 | One-cycle restart pulse to the streamer |
| sda_oe_o | output | 1 | Drive enable of the shared data line |
| sda_o | output | 1 | Value driven on the shared data line |

## Verification
The bench sweeps the bus-clock high time from one to four samples. A qualifier that is off by one would either accept a one-sample glitch as a mode switch or reject a legal two-sample high. It places matches at several points in the window and then probes one edge below and one edge at the 128-edge limit. A counter that fails to clear, or clears on a no-match report, a repeated falling edge or a match in the wrong mode, would revert early or late. It also drives all sixteen combinations of the two engines' drive inputs in each mode, so a mux that leaks the idle engine onto the line shows up directly. The restart pulse is counted cycle by cycle, which catches a pulse that is missing, stretched or repeated.

// File: rtl/serial_arb_pkg.sv
package serial_arb_pkg;

    typedef enum logic {
        MODE_STREAM = 1'b0,
        MODE_SLAVE  = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_comb chain_d[i] = async_i;
            end else begin : g_next
                always_comb chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/arb_fall_qual.sv
module arb_fall_qual #(
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic fall_ok_o
);

    localparam int HW = $clog2(MIN_HIGH + 1);
    localparam logic [HW-1:0] HMAX = HW'(MIN_HIGH);

    logic [HW-1:0] high_d;
    logic [HW-1:0] high_q;

    always_comb begin
        if (!sync_i)          high_d = '0;
        else if (high_q == HMAX) high_d = high_q;
        else                  high_d = high_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) high_q <= '0;
        else        high_q <= high_d;
    end

    assign fall_ok_o = !sync_i && (high_q == HMAX);

    // R3: a qualified fall needs the line high in the previous sample
    assert_fall_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ok_o |-> (!sync_i && $past(sync_i)));

endmodule

// File: rtl/arb_rise_det.sv
module arb_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);

    logic prev_d;
    logic prev_q;

    always_comb prev_d = sync_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sync_i && !prev_q;

endmodule

// File: rtl/arb_window_fsm.sv
module arb_window_fsm
    import serial_arb_pkg::*;
#(
    parameter int TIMEOUT = 128
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fall_ok_i,
    input  logic      tick_i,
    input  logic      match_i,
    output arb_mode_e mode_o,
    output logic      restart_o
);

    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        arb_mode_e     mode;
        logic [CW-1:0] cnt;
        logic          restart;
    } fsm_t;

    fsm_t st_d;
    fsm_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        case (st_q.mode)
            MODE_STREAM: begin
                if (fall_ok_i) begin
                    st_d.mode = MODE_SLAVE;
                    st_d.cnt  = '0;
                end
            end
            MODE_SLAVE: begin
                if (match_i) begin
                    st_d.cnt = '0;
                end else if (tick_i) begin
                    if (st_q.cnt == LAST) begin
                        st_d.mode    = MODE_STREAM;
                        st_d.cnt     = '0;
                        st_d.restart = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_STREAM, cnt: '0, restart: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign restart_o = st_q.restart;

    // R2: entering bidirectional mode requires a qualified fall
    assert_enter_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLAVE && $past(st_q.mode) == MODE_STREAM) |-> $past(fall_ok_i));

    // R4: no reversion before the window is full
    assert_no_early_revert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLAVE && !(tick_i && st_q.cnt == LAST)) |=> (st_q.mode == MODE_SLAVE));

    // R5: a match keeps the mode and restarts the window
    assert_match_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLAVE && match_i) |=> (st_q.mode == MODE_SLAVE && st_q.cnt == '0));

    // R9: the restart pulse lasts one cycle
    assert_restart_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.restart |=> !st_q.restart);

    // R11: no count is held while in transmit-only mode
    assert_idle_count_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_STREAM) |-> (st_q.cnt == '0));

endmodule

// File: rtl/serial_mode_arbiter.sv
module serial_mode_arbiter
    import serial_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2,
    parameter int TIMEOUT     = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic tclk_i,
    input  logic ctl_valid_i,
    input  logic ctl_hit_i,
    input  logic stream_oe_i,
    input  logic stream_sda_i,
    input  logic slave_oe_i,
    input  logic slave_sda_i,
    output logic stream_en_o,
    output logic slave_en_o,
    output logic stream_rst_o,
    output logic sda_oe_o,
    output logic sda_o
);

    logic      bclk_s;
    logic      tclk_s;
    logic      fall_ok;
    logic      tick;
    arb_mode_e mode;

    arb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_bsync (
        .clk(clk), .rst_n(rst_n), .async_i(bclk_i), .sync_o(bclk_s));

    arb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_tsync (
        .clk(clk), .rst_n(rst_n), .async_i(tclk_i), .sync_o(tclk_s));

    arb_fall_qual #(.MIN_HIGH(MIN_HIGH)) u_fall (
        .clk(clk), .rst_n(rst_n), .sync_i(bclk_s), .fall_ok_o(fall_ok));

    arb_rise_det u_rise (
        .clk(clk), .rst_n(rst_n), .sync_i(tclk_s), .rise_o(tick));

    arb_window_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fall_ok_i(fall_ok), .tick_i(tick),
        .match_i(ctl_valid_i && ctl_hit_i), .mode_o(mode), .restart_o(stream_rst_o));

    always_comb begin
        stream_en_o = (mode == MODE_STREAM);
        slave_en_o  = (mode == MODE_SLAVE);
        if (mode == MODE_SLAVE) begin
            sda_oe_o = slave_oe_i;
            sda_o    = slave_sda_i;
        end else begin
            sda_oe_o = stream_oe_i;
            sda_o    = stream_sda_i;
        end
    end

    // R10: exactly one engine owns the line
    assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({stream_en_o, slave_en_o}));

    // R9: a restart pulse coincides with the streamer regaining the line
    assert_restart_with_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stream_rst_o |-> (stream_en_o && $past(slave_en_o)));

endmodule

// File: tb/sim_serial_mode_arbiter.sv
module sim_serial_mode_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, tclk = 1'b0, cv = 1'b0, ch = 1'b0;
    logic soe = 1'b0, ssda = 1'b0, loe = 1'b0, lsda = 1'b0;
    logic stream_en, slave_en, stream_rst, sda_oe, sda;

    int checks = 0;
    int fails = 0;
    int rst_pulses = 0;
    int rst_len = 0;
    int max_len = 0;

    always #5ns clk = ~clk;

    serial_mode_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .tclk_i(tclk),
        .ctl_valid_i(cv), .ctl_hit_i(ch), .stream_oe_i(soe), .stream_sda_i(ssda),
        .slave_oe_i(loe), .slave_sda_i(lsda), .stream_en_o(stream_en),
        .slave_en_o(slave_en), .stream_rst_o(stream_rst), .sda_oe_o(sda_oe), .sda_o(sda));

    always @(negedge clk) begin
        if (stream_rst) begin
            if (rst_len == 0) rst_pulses++;
            rst_len++;
            if (rst_len > max_len) max_len = rst_len;
        end else begin
            rst_len = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            tclk = 1'b1; wait_n(2);
            tclk = 1'b0; wait_n(2);
        end
        wait_n(1);
    endtask

    task automatic bus_high(input int w);
        bclk = 1'b1; wait_n(w);
        bclk = 1'b0; wait_n(6);
    endtask

    task automatic enter();
        bus_high(4);
    endtask

    task automatic report(input logic hit);
        cv = 1'b1; ch = hit; wait_n(1);
        cv = 1'b0; ch = 1'b0; wait_n(1);
    endtask

    task automatic mux_sweep(input string req, input bit slave_mode);
        for (int v = 0; v < 16; v++) begin
            {soe, ssda, loe, lsda} = 4'(v);
            #1ns;
            chk(req, {sda_oe, sda}, slave_mode ? {loe, lsda} : {soe, ssda});
        end
        {soe, ssda, loe, lsda} = 4'b0;
    endtask

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1 stream_en", stream_en, 1);
        chk("R1 slave_en", slave_en, 0);
        chk("R1 stream_rst", stream_rst, 0);
        mux_sweep("R10 stream mux", 1'b0);

        // R7: match in transmit-only mode ignored
        report(1'b1);
        chk("R7 match ignored", slave_en, 0);

        // R3/R2: sweep high widths
        for (int w = 1; w <= 4; w++) begin
            bus_high(w);
            chk("R3/R2 width sweep", slave_en, (w >= 2) ? 1 : 0);
            if (slave_en) begin
                p = rst_pulses;
                pulses(128);
                chk("R4 revert after sweep", stream_en, 1);
                chk("R9 pulse count", rst_pulses - p, 1);
            end
        end
        chk("R9 pulse width", max_len, 1);

        // R11: edges in transmit-only mode do not count
        pulses(60);
        chk("R11 still stream", stream_en, 1);
        enter();
        chk("R2 entered", slave_en, 1);
        mux_sweep("R10 slave mux", 1'b1);
        pulses(127);
        chk("R4/R11 after 127", slave_en, 1);
        p = rst_pulses;
        pulses(1);
        chk("R4 after 128", stream_en, 1);
        chk("R9 one pulse", rst_pulses - p, 1);

        // R5: match restarts window at several positions
        for (int k = 1; k <= 127; k += 63) begin
            enter();
            pulses(k);
            report(1'b1);
            pulses(127);
            chk("R5 hold after match", slave_en, 1);
            pulses(1);
            chk("R5 revert after match", stream_en, 1);
        end

        // R6: no-match report does not restart
        enter();
        pulses(100);
        report(1'b0);
        chk("R6 mode kept", slave_en, 1);
        pulses(28);
        chk("R6 no restart", stream_en, 1);

        // R8: repeated fall ignored
        enter();
        pulses(100);
        enter();
        chk("R8 still slave", slave_en, 1);
        pulses(27);
        chk("R8 before limit", slave_en, 1);
        pulses(1);
        chk("R8 no restart", stream_en, 1);
        chk("R9 final width", max_len, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule